// File: doc/BRIEF.md
# Debugger Byte-Wise Bus Stealer

This block lets a serial debug link read and write system memory while the processor keeps executing. A command source hands it a start address, a byte count and a direction. The block then takes the shared bus for one single-byte access at a time and hands it back to the CPU straight after. It never holds the bus for a whole multi-byte command.

The serial link paces the accesses. In a write command, every byte that the serial receiver reports (`rx_valid`) is written to memory in one bus cycle. In a read command, each time the serial transmitter reports empty (`tx_empty`), one byte is read from memory. That byte is then loaded into the transmitter with a one-cycle `tx_load` strobe, and the load clears the empty condition. Between accesses the address steps up by one and the remaining count steps down. The command ends when the count reaches zero.

The controller is a five-state machine:
- `S_IDLE`: no command. Leaves for `S_WAIT` on a command with a non-zero count.
- `S_WAIT`: waits for the trigger of the current direction. Leaves for `S_REQ`.
- `S_REQ`: raises the bus request and holds it until a grant is seen. Leaves for `S_XFER`.
- `S_XFER`: the single-cycle memory access. Goes to `S_WAIT` (more write bytes), to `S_IDLE` (last write byte) or to `S_LOAD` (any read).
- `S_LOAD`: pulses `tx_load`. Goes to `S_WAIT`, or to `S_IDLE` when the count is exhausted.

Top module: `dbg_byte_stealer`

## Requirements
- R1: After reset, `busy`, `bus_req`, `mem_we`, `mem_re` and `tx_load` are all 0.
- R2: A command is taken only when `busy` is 0 and `cmd_count` is non-zero, and `busy` is 1 in the following cycle. A command with zero count, or any command while `busy` is 1, is ignored.
- R3: In a write command (`cmd_write`=1), each `rx_valid` pulse seen in `S_WAIT` gives exactly one `mem_we` cycle, with `mem_wdata` equal to that received byte.
- R4: In a read command (`cmd_write`=0), each `tx_empty` seen in `S_WAIT` gives exactly one `mem_re` cycle. In the cycle after it, `tx_load` is 1 and `tx_data` carries the byte read.
- R5: `bus_req` rises in the cycle after a trigger and stays 1 until a cycle with `bus_grant`=1. The access follows in the next cycle, and `bus_req` is 0 in the cycle after the access. With a grant arriving G cycles after the request, `bus_req` is high for G+2 cycles per byte.
- R6: `mem_we` or `mem_re` is asserted only while both `bus_req` and `bus_grant` are 1, and never both at once.
- R7: `bus_req` rises exactly once per byte, and is never 1 while `busy` is 0.
- R8: The first access uses `cmd_addr`, and each later access uses the previous address plus one. A command makes exactly `cmd_count` accesses. `busy` drops after the last access (write) or after the last `tx_load` (read).
- R9: `tx_empty` has no effect during a write command, and `rx_valid` has no effect during a read command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command strobe |
| cmd_addr | input | AW | Start address |
| cmd_count | input | CW | Number of bytes |
| cmd_write | input | 1 | 1 = write command, 0 = read command |
| busy | output | 1 | Command in progress |
| rx_valid | input | 1 | Serial receiver has a byte |
| rx_data | input | 8 | Received byte |
| tx_empty | input | 1 | Serial transmitter is empty |
| tx_load | output | 1 | Load strobe to transmitter |
| tx_data | output | 8 | Byte for the transmitter |
| bus_req | output | 1 | Bus request to the CPU |
| bus_grant | input | 1 | Bus grant from the CPU |
| mem_addr | output | AW | Memory byte address |
| mem_wdata | output | 8 | Memory write data |
| mem_we | output | 1 | Memory write strobe |
| mem_re | output | 1 | Memory read strobe |
| mem_rdata | input | 8 | Memory read data (combinational) |

## Verification
The bench stretches the grant latency from one to four cycles and withholds the grant for a long time. A design that accessed memory before the grant, or dropped its request early, would show an access while the grant is low, or a wrong count of request-high cycles. Commands that start near an address boundary, single-byte commands and a zero-count command expose off-by-one errors in the address or count, which would show up as missing bytes, extra bytes or `busy` stuck high. Triggers from the unused direction during a command, and a second command while busy, would cause stray memory strobes or a redirected address if they were not ignored. Read-back through the transmitter checks that each loaded byte is the one just read, and not a stale value.

// File: rtl/dbs_pkg.sv
package dbs_pkg;
    typedef enum logic [2:0] {
        S_IDLE = 3'd0,
        S_WAIT = 3'd1,
        S_REQ  = 3'd2,
        S_XFER = 3'd3,
        S_LOAD = 3'd4
    } dbs_state_e;
endpackage

// File: rtl/dbs_cursor.sv
// Address and remaining-count tracker for the current command.
module dbs_cursor #(
    parameter int AW = 16,
    parameter int CW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic          step,
    input  logic [AW-1:0] ld_addr,
    input  logic [CW-1:0] ld_count,
    input  logic          ld_write,
    output logic [AW-1:0] addr,
    output logic          is_write,
    output logic          last,
    output logic          empty
);
    logic [CW-1:0] remain;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr     <= '0;
            remain   <= '0;
            is_write <= 1'b0;
        end else if (load) begin
            addr     <= ld_addr;
            remain   <= ld_count;
            is_write <= ld_write;
        end else if (step) begin
            addr     <= addr + AW'(1);
            remain   <= remain - CW'(1);
        end
    end

    assign last  = (remain == CW'(1));
    assign empty = (remain == '0);
endmodule

// File: rtl/dbs_bytebuf.sv
// Holds the byte waiting to be written and the byte just read.
module dbs_bytebuf #(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wcap,
    input  logic [DW-1:0] wbyte_in,
    input  logic          rcap,
    input  logic [DW-1:0] rbyte_in,
    output logic [DW-1:0] wbyte,
    output logic [DW-1:0] rbyte
);
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wbyte <= '0;
            rbyte <= '0;
        end else begin
            if (wcap) wbyte <= wbyte_in;
            if (rcap) rbyte <= rbyte_in;
        end
    end
endmodule

// File: rtl/dbs_fsm.sv
// Sequencer: one bus steal per byte, paced by the serial link.
module dbs_fsm
    import dbs_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic cmd_take,
    input  logic is_write,
    input  logic last,
    input  logic empty,
    input  logic rx_valid,
    input  logic tx_empty,
    input  logic bus_grant,
    output logic busy,
    output logic load,
    output logic step,
    output logic wcap,
    output logic bus_req,
    output logic mem_we,
    output logic mem_re,
    output logic tx_load
);
    dbs_state_e state, state_nx;

    always_ff @(posedge clk) begin
        if (!rst_n) state <= S_IDLE;
        else        state <= state_nx;
    end

    always_comb begin
        state_nx = state;
        busy     = 1'b1;
        load     = 1'b0;
        step     = 1'b0;
        wcap     = 1'b0;
        bus_req  = 1'b0;
        mem_we   = 1'b0;
        mem_re   = 1'b0;
        tx_load  = 1'b0;
        unique case (state)
            S_IDLE: begin
                busy = 1'b0;
                if (cmd_take) begin
                    load     = 1'b1;
                    state_nx = S_WAIT;
                end
            end
            S_WAIT: begin
                if (is_write) begin
                    if (rx_valid) begin
                        wcap     = 1'b1;
                        state_nx = S_REQ;
                    end
                end else if (tx_empty) begin
                    state_nx = S_REQ;
                end
            end
            S_REQ: begin
                bus_req = 1'b1;
                if (bus_grant) state_nx = S_XFER;
            end
            S_XFER: begin
                bus_req = 1'b1;
                step    = 1'b1;
                if (is_write) begin
                    mem_we   = 1'b1;
                    state_nx = last ? S_IDLE : S_WAIT;
                end else begin
                    mem_re   = 1'b1;
                    state_nx = S_LOAD;
                end
            end
            S_LOAD: begin
                tx_load  = 1'b1;
                state_nx = empty ? S_IDLE : S_WAIT;
            end
            default: state_nx = S_IDLE;
        endcase
    end
endmodule

// File: rtl/dbg_byte_stealer.sv
module dbg_byte_stealer #(
    parameter int AW = 16,
    parameter int CW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cmd_valid,
    input  logic [AW-1:0] cmd_addr,
    input  logic [CW-1:0] cmd_count,
    input  logic          cmd_write,
    output logic          busy,
    input  logic          rx_valid,
    input  logic [7:0]    rx_data,
    input  logic          tx_empty,
    output logic          tx_load,
    output logic [7:0]    tx_data,
    output logic          bus_req,
    input  logic          bus_grant,
    output logic [AW-1:0] mem_addr,
    output logic [7:0]    mem_wdata,
    output logic          mem_we,
    output logic          mem_re,
    input  logic [7:0]    mem_rdata
);
    logic cmd_take, load, step, wcap, is_write, last, empty;

    assign cmd_take = cmd_valid && (cmd_count != '0);

    dbs_fsm u_fsm (
        .clk(clk), .rst_n(rst_n), .cmd_take(cmd_take), .is_write(is_write),
        .last(last), .empty(empty), .rx_valid(rx_valid), .tx_empty(tx_empty),
        .bus_grant(bus_grant), .busy(busy), .load(load), .step(step),
        .wcap(wcap), .bus_req(bus_req), .mem_we(mem_we), .mem_re(mem_re),
        .tx_load(tx_load)
    );

    dbs_cursor #(.AW(AW), .CW(CW)) u_cursor (
        .clk(clk), .rst_n(rst_n), .load(load), .step(step),
        .ld_addr(cmd_addr), .ld_count(cmd_count), .ld_write(cmd_write),
        .addr(mem_addr), .is_write(is_write), .last(last), .empty(empty)
    );

    dbs_bytebuf #(.DW(8)) u_buf (
        .clk(clk), .rst_n(rst_n), .wcap(wcap), .wbyte_in(rx_data),
        .rcap(mem_re), .rbyte_in(mem_rdata), .wbyte(mem_wdata), .rbyte(tx_data)
    );
endmodule

// File: rtl/dbs_chk.sv
module dbs_chk #(
    parameter int AW = 16,
    parameter int CW = 8
) (
    input logic          clk,
    input logic          rst_n,
    input logic          cmd_valid,
    input logic [CW-1:0] cmd_count,
    input logic          busy,
    input logic          tx_load,
    input logic          bus_req,
    input logic          bus_grant,
    input logic [AW-1:0] mem_addr,
    input logic          mem_we,
    input logic          mem_re
);
    logic          seen;
    logic [AW-1:0] prev_addr;
    logic          strobe;

    assign strobe = mem_we || mem_re;

    always_ff @(posedge clk) begin
        if (!rst_n || !busy) begin
            seen      <= 1'b0;
            prev_addr <= '0;
        end else if (strobe) begin
            seen      <= 1'b1;
            prev_addr <= mem_addr;
        end
    end

    p_accept_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && cmd_valid && cmd_count != '0) |=> busy);
    p_zero_count_ignored_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && cmd_valid && cmd_count == '0) |=> !busy);
    p_load_after_read_r4: assert property (@(posedge clk) disable iff (!rst_n)
        mem_re |=> tx_load);
    p_load_only_after_read_r4: assert property (@(posedge clk) disable iff (!rst_n)
        tx_load |-> $past(mem_re));
    p_hold_req_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && !bus_grant) |=> bus_req);
    p_release_after_access_r5: assert property (@(posedge clk) disable iff (!rst_n)
        strobe |=> !bus_req);
    p_grant_before_strobe_r6: assert property (@(posedge clk) disable iff (!rst_n)
        strobe |-> (bus_req && bus_grant));
    p_single_strobe_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $countones({mem_we, mem_re}) <= 1);
    p_req_only_busy_r7: assert property (@(posedge clk) disable iff (!rst_n)
        bus_req |-> busy);
    p_addr_step_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (strobe && seen) |-> (mem_addr == prev_addr + AW'(1)));
endmodule

bind dbg_byte_stealer dbs_chk #(.AW(AW), .CW(CW)) u_chk (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_count(cmd_count),
    .busy(busy), .tx_load(tx_load), .bus_req(bus_req), .bus_grant(bus_grant),
    .mem_addr(mem_addr), .mem_we(mem_we), .mem_re(mem_re)
);

// File: tb/sim_dbg_byte_stealer.sv
`timescale 1ns/1ps
module sim_dbg_byte_stealer;
    localparam int TCLK = 10;
    localparam int AW = 16;
    localparam int CW = 8;
    localparam int NV = 6;
    // {write[7:0], addr[15:0], count[7:0], seed[7:0], grant_delay[7:0]}
    localparam logic [47:0] VEC [NV] = '{
        48'h01_0010_04_A0_00,
        48'h00_0010_04_00_01,
        48'h00_00F0_06_00_00,
        48'h01_0123_01_33_02,
        48'h01_00FE_03_C1_03,
        48'h00_0120_05_00_03
    };

    logic clk = 0, rst_n = 0;
    logic cmd_valid = 0, cmd_write = 0;
    logic [AW-1:0] cmd_addr = '0;
    logic [CW-1:0] cmd_count = '0;
    logic busy, rx_valid = 0, tx_empty, tx_load, bus_req, bus_grant, mem_we, mem_re;
    logic [7:0] rx_data = 0, tx_data, mem_wdata, mem_rdata;
    logic [AW-1:0] mem_addr;

    int total = 0, bad = 0;
    int gnt_dly = 0;
    logic gnt_block = 0;
    logic mon_clr = 0;
    logic [AW-1:0] exp_base = '0;
    logic [7:0] shadow [256];
    logic [7:0] mem [256];
    logic [7:0] txlog [64];
    int rx_n, gcnt, gap;
    int we_n, re_n, req_rise, req_cyc, addr_err, ld_err;
    logic [AW-1:0] mon_addr;
    logic prev_req, prev_re;

    always #(TCLK/2) clk = ~clk;

    dbg_byte_stealer #(.AW(AW), .CW(CW)) u0 (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_addr(cmd_addr),
        .cmd_count(cmd_count), .cmd_write(cmd_write), .busy(busy),
        .rx_valid(rx_valid), .rx_data(rx_data), .tx_empty(tx_empty),
        .tx_load(tx_load), .tx_data(tx_data), .bus_req(bus_req),
        .bus_grant(bus_grant), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_we(mem_we), .mem_re(mem_re), .mem_rdata(mem_rdata)
    );

    // CPU-side arbiter: grants gnt_dly+1 cycles after the request is seen.
    always @(posedge clk) begin
        if (!rst_n || !bus_req || gnt_block) begin
            bus_grant <= 1'b0;
            gcnt      <= 0;
        end else if (gcnt == gnt_dly) bus_grant <= 1'b1;
        else gcnt <= gcnt + 1;
    end

    // Memory model.
    assign mem_rdata = mem[mem_addr[7:0]];
    always @(posedge clk) begin
        if (!rst_n) begin
            for (int k = 0; k < 256; k++) mem[k] <= 8'(k) ^ 8'h5A;
        end else if (mem_we) mem[mem_addr[7:0]] <= mem_wdata;
    end

    // Serial transmitter model.
    always @(posedge clk) begin
        if (!rst_n) begin
            tx_empty <= 1'b1; gap <= 0; rx_n <= 0;
        end else begin
            if (mon_clr) rx_n <= 0;
            if (tx_load) begin
                txlog[rx_n[5:0]] <= tx_data;
                if (!mon_clr) rx_n <= rx_n + 1;
                tx_empty <= 1'b0;
                gap      <= 3;
            end else if (gap != 0) begin
                gap <= gap - 1;
                if (gap == 1) tx_empty <= 1'b1;
            end
        end
    end

    // Observation counters.
    always @(posedge clk) begin
        if (!rst_n || mon_clr) begin
            we_n <= 0; re_n <= 0; req_rise <= 0; req_cyc <= 0;
            addr_err <= 0; ld_err <= 0; mon_addr <= exp_base;
            prev_req <= 1'b0; prev_re <= 1'b0;
        end else begin
            prev_req <= bus_req;
            prev_re  <= mem_re;
            if (bus_req) req_cyc <= req_cyc + 1;
            if (bus_req && !prev_req) req_rise <= req_rise + 1;
            if (mem_we) we_n <= we_n + 1;
            if (mem_re) re_n <= re_n + 1;
            if (mem_we || mem_re) begin
                if (mem_addr != mon_addr) addr_err <= addr_err + 1;
                mon_addr <= mon_addr + AW'(1);
            end
            if (tx_load != prev_re) ld_err <= ld_err + 1;
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic start(input bit wr, input logic [AW-1:0] a, input logic [CW-1:0] n);
        @(negedge clk); exp_base = a; mon_clr = 1;
        @(negedge clk); mon_clr = 0;
        cmd_valid = 1; cmd_write = wr; cmd_addr = a; cmd_count = n;
        @(negedge clk); cmd_valid = 0;
    endtask

    task automatic send_byte(input logic [7:0] b);
        rx_valid = 1; rx_data = b;
        @(negedge clk); rx_valid = 0;
        repeat (8) @(negedge clk);
    endtask

    task automatic wait_idle();
        for (int t = 0; t < 400 && busy; t++) @(negedge clk);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog actual=1 expected=0");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        for (int k = 0; k < 256; k++) shadow[k] = 8'(k) ^ 8'h5A;
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R1 reset state
        chk(!busy && !bus_req && !mem_we && !mem_re && !tx_load, "R1 idle outputs",
            {busy, bus_req, mem_we, mem_re, tx_load}, 0);

        // Vector table
        for (int v = 0; v < NV; v++) begin
            automatic bit wr = VEC[v][47:40] != 0;
            automatic logic [AW-1:0] a = VEC[v][39:24];
            automatic int n = int'(VEC[v][23:16]);
            automatic logic [7:0] seed = VEC[v][15:8];
            automatic int mism = 0;
            gnt_dly = int'(VEC[v][7:0]);
            start(wr, a, CW'(n));
            chk(busy, "R2 busy after accept", busy, 1);
            if (wr) begin
                for (int i = 0; i < n; i++) begin
                    send_byte(seed + 8'(3 * i));
                    shadow[8'(a + AW'(i))] = seed + 8'(3 * i);
                end
            end
            wait_idle();
            @(negedge clk);
            chk(!busy, "R8 busy drops at end", busy, 0);
            chk(we_n + re_n == n, "R8 access count", we_n + re_n, n);
            chk(addr_err == 0, "R8 address sequence", addr_err, 0);
            chk(req_rise == n, "R7 one request per byte", req_rise, n);
            chk(req_cyc == n * (gnt_dly + 3), "R5 request length", req_cyc, n * (gnt_dly + 3));
            if (wr) begin
                chk(re_n == 0, "R9 tx_empty ignored in write", re_n, 0);
                for (int i = 0; i < n; i++)
                    if (mem[8'(a + AW'(i))] != shadow[8'(a + AW'(i))]) mism++;
                chk(mism == 0, "R3 written bytes", mism, 0);
            end else begin
                chk(rx_n == n, "R4 loads per read", rx_n, n);
                chk(ld_err == 0, "R4 load follows read", ld_err, 0);
                for (int i = 0; i < n; i++)
                    if (txlog[i] != shadow[8'(a + AW'(i))]) mism++;
                chk(mism == 0, "R4 read bytes", mism, 0);
            end
        end

        // R2 zero count ignored
        gnt_dly = 0;
        start(1'b0, 16'h0050, '0);
        chk(!busy, "R2 zero count ignored", busy, 0);
        repeat (10) @(negedge clk);
        chk(re_n + we_n == 0, "R2 zero count no access", re_n + we_n, 0);

        // R2 command while busy ignored
        start(1'b1, 16'h0040, 8'd2);
        cmd_valid = 1; cmd_write = 0; cmd_addr = 16'h0080; cmd_count = 8'd5;
        @(negedge clk); cmd_valid = 0;
        send_byte(8'h11); send_byte(8'h22);
        wait_idle(); @(negedge clk);
        chk(we_n == 2 && re_n == 0, "R2 busy command ignored", we_n + 10 * re_n, 2);
        chk(addr_err == 0 && mem[8'h41] == 8'h22, "R2 original address kept", addr_err, 0);

        // R9 rx_valid ignored during read
        start(1'b0, 16'h0060, 8'd3);
        for (int i = 0; i < 6; i++) begin
            rx_valid = 1; rx_data = 8'hEE; @(negedge clk);
        end
        rx_valid = 0;
        wait_idle(); @(negedge clk);
        chk(we_n == 0, "R9 rx_valid ignored in read", we_n, 0);
        chk(mem[8'h61] == shadow[8'h61], "R9 memory untouched", mem[8'h61], shadow[8'h61]);
        chk(re_n == 3, "R4 reads with noise", re_n, 3);

        // R5 grant withheld
        gnt_block = 1;
        start(1'b1, 16'h0070, 8'd1);
        send_byte(8'h99);
        repeat (20) @(negedge clk);
        chk(bus_req && we_n == 0, "R5 request held without grant", we_n, 0);
        chk(mem[8'h70] == shadow[8'h70], "R6 no write before grant", mem[8'h70], shadow[8'h70]);
        gnt_block = 0;
        wait_idle(); @(negedge clk);
        chk(we_n == 1 && mem[8'h70] == 8'h99, "R3 write after grant", mem[8'h70], 8'h99);
        chk(!bus_req, "R7 request low when idle", bus_req, 0);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule